// File: doc/BRIEF.md
# Sixteen-Bit Modulo Timer with Coherent Byte Access

This block is a 16-bit up-counter that wraps at a programmable limit and is reached through an 8-bit register bus. Software sees the count as two read-only bytes and the limit as two writable bytes. Because the bus is narrower than the counter, the block guards both directions of access:

- Reading the upper count byte captures the lower byte, so that a following read of the lower byte returns a value that belongs with the upper byte already returned.
- A write to the upper limit byte is staged. The full limit takes effect only when the lower byte is written.
- Between those two writes, the overflow flag and its interrupt are held off.

The counter advances on cycles where a one-cycle timer-clock enable is high, unless a stop bit is set. When the count reaches the limit, the overflow flag rises. On the following timer tick the count restarts at zero. Software can zero the counter at any time through a reset bit in the control byte. The flag is cleared by a read-then-write sequence. The interrupt line is the flag gated by an enable bit.

Top module: `mod_timer16`

## Requirements
- R1: After system reset the count is 0x0000, the limit reads 0xFFFF, and the status byte reads 0x00. The flag, the interrupt enable and the stop bit are all clear, and `ovfIrq` is low.
- R2: The register map is as follows. Address 0 is status/control, with bit 7 = overflow flag, bit 6 = interrupt enable, bit 5 = stop, and bit 4 = counter reset (write-only, reads 0). Addresses 1 and 2 are the upper and lower count bytes. Addresses 3 and 4 are the upper and lower limit bytes, and both read back the active limit.
- R3: A read of the upper count byte returns count bits 15:8 and captures count bits 7:0. The next read of the lower byte returns that captured value.
- R4: While a captured lower byte is pending, further reads of the upper byte do not recapture it. The capture holds for any length of time and is released only by a lower-byte read.
- R5: A lower-byte read with no capture pending returns the live count bits 7:0.
- R6: Writing 1 to bit 4 of address 0 sets the count to 0x0000 on the next cycle.
- R7: The count increases by one on each cycle with `tickEn` high and the stop bit clear. With the stop bit set, the count holds.
- R8: On a tick that brings the count to the limit, the flag is set. On the next tick after that the count becomes 0x0000. After N ticks from zero, the count is N mod (limit+1).
- R9: A write to the upper limit byte does not change the active limit. A write to the lower limit byte loads the active limit with the staged upper byte and the written lower byte, both at once.
- R10: After a write to the upper limit byte and until the lower limit byte is written, the flag is not set and `ovfIrq` stays low.
- R11: Writing 0 to bit 7 of address 0 clears the flag only if address 0 was read while the flag was set since the last write to address 0. Writing 1 to bit 7 leaves the flag unchanged.
- R12: `ovfIrq` is high exactly when the flag and the interrupt enable are both set, outside the window of R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous system reset |
| tickEn | input | 1 | One-cycle timer-clock enable |
| busAddr | input | 3 | Register address |
| busRd | input | 1 | Read strobe, one cycle per access |
| busWr | input | 1 | Write strobe, one cycle per access |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, valid combinationally during `busRd` |
| ovfIrq | output | 1 | Overflow interrupt request |

## Verification
The coherence test reads the upper count byte when the lower byte is 0xFE, lets the count cross a byte boundary, and reads the upper byte again before the lower byte. A design that recaptures on the second upper read returns the new lower byte instead of 0xFE. A design that never releases the capture returns a stale lower byte on the following read.

The staged-limit test writes only the upper limit byte and checks two things. First, the wrap point must stay at the old limit, since an eager update would carry the count past it. Second, the flag must stay down, since a design without inhibition raises it.

The flag-clear test writes 0 to the flag without first reading status, and expects the flag to survive. It also checks the interrupt with the enable low.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_STAT = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNTH = 3'd1;
  localparam logic [ADDR_W-1:0] A_CNTL = 3'd2;
  localparam logic [ADDR_W-1:0] A_MODH = 3'd3;
  localparam logic [ADDR_W-1:0] A_MODL = 3'd4;

  localparam int B_OVF  = 7;
  localparam int B_IE   = 6;
  localparam int B_STOP = 5;
  localparam int B_TRST = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClear;
    logic cntAdvance;
    logic modHiWr;
    logic modLoWr;
    logic loCapture;
  } tmrStrb_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tickEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busRd,
  input  logic                busWr,
  input  logic [DATA_W-1:0]   busWdata,
  input  logic                reachMod,
  output tmrStrb_t            strb,
  output logic [DATA_W-1:0]   statusByte,
  output logic                loHeld,
  output logic                ovfIrq
);
  logic ovfFlag, clrArmed, ieBit, stopBit, modInhibit;
  logic wrStat, rdStat, loRelease, ovfSet, ovfClr;

  always_comb begin
    wrStat          = busWr && (busAddr == A_STAT);
    rdStat          = busRd && (busAddr == A_STAT);
    loRelease       = busRd && (busAddr == A_CNTL);
    strb.cntClear   = wrStat && busWdata[B_TRST];
    strb.cntAdvance = tickEn && !stopBit;
    strb.modHiWr    = busWr && (busAddr == A_MODH);
    strb.modLoWr    = busWr && (busAddr == A_MODL);
    strb.loCapture  = busRd && (busAddr == A_CNTH) && !loHeld;
    ovfSet          = strb.cntAdvance && !strb.cntClear && reachMod && !modInhibit;
    ovfClr          = wrStat && clrArmed && !busWdata[B_OVF];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovfFlag    <= 1'b0;
      clrArmed   <= 1'b0;
      ieBit      <= 1'b0;
      stopBit    <= 1'b0;
      modInhibit <= 1'b0;
      loHeld     <= 1'b0;
    end else begin
      if (ovfSet)      ovfFlag <= 1'b1;
      else if (ovfClr) ovfFlag <= 1'b0;

      if (rdStat && ovfFlag) clrArmed <= 1'b1;
      else if (wrStat)       clrArmed <= 1'b0;

      if (wrStat) begin
        ieBit   <= busWdata[B_IE];
        stopBit <= busWdata[B_STOP];
      end

      if (strb.modHiWr)      modInhibit <= 1'b1;
      else if (strb.modLoWr) modInhibit <= 1'b0;

      if (strb.loCapture) loHeld <= 1'b1;
      else if (loRelease) loHeld <= 1'b0;
    end
  end

  always_comb begin
    statusByte         = '0;
    statusByte[B_OVF]  = ovfFlag;
    statusByte[B_IE]   = ieBit;
    statusByte[B_STOP] = stopBit;
    ovfIrq             = ovfFlag && ieBit && !modInhibit;
  end

  // R4: the capture persists until a lower-byte read
  p_hold_until_lo_r4: assert property (@(posedge clk) disable iff (!rstN)
    (loHeld && !loRelease) |=> loHeld);

  // R10: no flag rise while a limit write is half done
  p_inhibit_blocks_r10: assert property (@(posedge clk) disable iff (!rstN)
    (modInhibit && !ovfFlag) |=> !ovfFlag);

  // R11: the flag only falls after an arming read
  p_clear_needs_read_r11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ovfFlag) |-> $past(clrArmed));
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  tmrStrb_t            strb,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWdata,
  input  logic [DATA_W-1:0]   statusByte,
  input  logic                loHeld,
  output logic [DATA_W-1:0]   busRdata,
  output logic                reachMod
);
  localparam int CNT_W = 2 * DATA_W;

  logic [CNT_W-1:0]  cnt, cntNext, modVal;
  logic [DATA_W-1:0] modHiStage, loBuf;

  always_comb begin
    cntNext  = (cnt == modVal) ? '0 : cnt + CNT_W'(1);
    reachMod = (cntNext == modVal);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt        <= '0;
      modVal     <= '1;
      modHiStage <= '1;
      loBuf      <= '0;
    end else begin
      if (strb.cntClear)        cnt <= '0;
      else if (strb.cntAdvance) cnt <= cntNext;
      if (strb.modHiWr) modHiStage <= busWdata;
      if (strb.modLoWr) modVal <= {modHiStage, busWdata};
      if (strb.loCapture) loBuf <= cnt[DATA_W-1:0];
    end
  end

  always_comb begin
    unique case (busAddr)
      A_STAT:  busRdata = statusByte;
      A_CNTH:  busRdata = cnt[CNT_W-1:DATA_W];
      A_CNTL:  busRdata = loHeld ? loBuf : cnt[DATA_W-1:0];
      A_MODH:  busRdata = modVal[CNT_W-1:DATA_W];
      A_MODL:  busRdata = modVal[DATA_W-1:0];
      default: busRdata = '0;
    endcase
  end

  // R6: counter reset lands next cycle
  p_trst_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntClear |=> (cnt == '0));

  // R8: a tick at the limit restarts from zero
  p_wrap_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cntAdvance && !strb.cntClear && cnt == modVal) |=> (cnt == '0));

  // R9: active limit changes only on a lower-byte write
  p_mod_atomic_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.modLoWr |=> $stable(modVal));

  // R4: a pending capture is not overwritten
  p_lo_frozen_r4: assert property (@(posedge clk) disable iff (!rstN)
    loHeld |=> $stable(loBuf));
endmodule

// File: rtl/mod_timer16.sv
module mod_timer16
  import tmr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tickEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busRd,
  input  logic                busWr,
  input  logic [DATA_W-1:0]   busWdata,
  output logic [DATA_W-1:0]   busRdata,
  output logic                ovfIrq
);
  tmrStrb_t          strb;
  logic [DATA_W-1:0] statusByte;
  logic              loHeld, reachMod;

  tmr_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busAddr(busAddr),
    .busRd(busRd), .busWr(busWr), .busWdata(busWdata),
    .reachMod(reachMod), .strb(strb), .statusByte(statusByte),
    .loHeld(loHeld), .ovfIrq(ovfIrq)
  );

  tmr_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busAddr(busAddr),
    .busWdata(busWdata), .statusByte(statusByte), .loHeld(loHeld),
    .busRdata(busRdata), .reachMod(reachMod)
  );

  // R12: interrupt only with flag and enable both visible in status
  p_irq_gated_r12: assert property (@(posedge clk) disable iff (!rstN)
    ovfIrq |-> (statusByte[B_OVF] && statusByte[B_IE]));
endmodule

// File: tb/mod_timer16_tb.sv
module mod_timer16_tb;
  import tmr_pkg::*;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [15:0] modV;
    logic [15:0] ticks;
    logic [15:0] expCnt;
    logic        expFlag;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{16'h0005, 16'd3,   16'd3,   1'b0},
    '{16'h0005, 16'd5,   16'd5,   1'b1},
    '{16'h0005, 16'd6,   16'd0,   1'b1},
    '{16'h0005, 16'd13,  16'd1,   1'b1},
    '{16'h0000, 16'd4,   16'd0,   1'b1},
    '{16'h0001, 16'd3,   16'd1,   1'b1},
    '{16'h0010, 16'd16,  16'd16,  1'b1},
    '{16'h0100, 16'd300, 16'd43,  1'b1},
    '{16'hFFFF, 16'd100, 16'd100, 1'b0}
  };

  logic clk = 1'b0, rstN = 1'b0, tickEn = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic busRd = 1'b0, busWr = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic ovfIrq;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mod_timer16 u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busAddr(busAddr),
    .busRd(busRd), .busWr(busWr), .busWdata(busWdata),
    .busRdata(busRdata), .ovfIrq(ovfIrq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [7:0] d);
    busRd = 1'b1; busAddr = a;
    #1 d = busRdata;
    @(posedge clk); @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      tickEn = 1'b1;
      repeat (n) @(posedge clk);
      @(negedge clk);
      tickEn = 1'b0;
    end
  endtask

  task automatic rdCnt(output logic [15:0] v);
    logic [7:0] h, l;
    rd(A_CNTH, h);
    rd(A_CNTL, l);
    v = {h, l};
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] b, h1, h2, l1, l2;
    logic [15:0] v;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 / R2: reset values through the map
    rd(A_STAT, b); chk("R1 status", {8'h0, b}, 16'h0000);
    rdCnt(v);      chk("R1 count", v, 16'h0000);
    rd(A_MODH, b); chk("R1 R2 limit hi", {8'h0, b}, 16'h00FF);
    rd(A_MODL, b); chk("R1 R2 limit lo", {8'h0, b}, 16'h00FF);
    chk("R1 irq", {15'h0, ovfIrq}, 16'h0000);

    // R8: vector table of limit / tick count / expected count and flag
    for (int i = 0; i < NVEC; i++) begin
      wr(A_MODH, VECS[i].modV[15:8]);
      wr(A_MODL, VECS[i].modV[7:0]);
      wr(A_STAT, 8'h10);
      rd(A_STAT, b);
      wr(A_STAT, 8'h00);
      ticks(int'(VECS[i].ticks));
      rdCnt(v);
      chk($sformatf("R8 vec%0d count", i), v, VECS[i].expCnt);
      rd(A_STAT, b);
      chk($sformatf("R8 vec%0d flag", i), {15'h0, b[B_OVF]}, {15'h0, VECS[i].expFlag});
    end

    // R3 / R4 / R5: coherent byte reads across a carry
    wr(A_STAT, 8'h10);
    ticks(510);
    rd(A_CNTH, h1); chk("R3 hi byte", {8'h0, h1}, 16'h0001);
    ticks(5);
    repeat (50) @(negedge clk);
    rd(A_CNTH, h2); chk("R4 second hi read", {8'h0, h2}, 16'h0002);
    rd(A_CNTL, l1); chk("R4 held lo byte", {8'h0, l1}, 16'h00FE);
    rd(A_CNTL, l2); chk("R5 live lo byte", {8'h0, l2}, 16'h0003);

    // R6 / R7: stop holds, reset bit zeroes
    wr(A_STAT, 8'h20);
    ticks(10);
    rdCnt(v); chk("R7 stopped count", v, 16'h0203);
    wr(A_STAT, 8'h00);
    ticks(2);
    rdCnt(v); chk("R7 running count", v, 16'h0205);
    wr(A_STAT, 8'h10);
    rdCnt(v); chk("R6 counter reset", v, 16'h0000);

    // R9 / R10: staged limit, inhibited flag
    wr(A_MODH, 8'h00); wr(A_MODL, 8'h05);
    wr(A_STAT, 8'h50);
    rd(A_STAT, b); wr(A_STAT, 8'h40);
    wr(A_MODH, 8'h01);
    rd(A_MODH, b); chk("R9 staged hi not active", {8'h0, b}, 16'h0000);
    ticks(5);
    rd(A_STAT, b); chk("R10 flag inhibited", {15'h0, b[B_OVF]}, 16'h0000);
    chk("R10 irq inhibited", {15'h0, ovfIrq}, 16'h0000);
    ticks(1);
    rdCnt(v); chk("R9 wrap at old limit", v, 16'h0000);
    wr(A_MODL, 8'h03);
    rd(A_MODH, b); chk("R9 committed hi", {8'h0, b}, 16'h0001);
    rd(A_MODL, b); chk("R9 committed lo", {8'h0, b}, 16'h0003);
    wr(A_STAT, 8'h50);
    ticks(259);
    chk("R12 irq raised", {15'h0, ovfIrq}, 16'h0001);

    // R11: clear requires a prior status read
    wr(A_STAT, 8'h40);
    chk("R11 blind write keeps flag", {15'h0, ovfIrq}, 16'h0001);
    rd(A_STAT, b); chk("R11 flag visible", {15'h0, b[B_OVF]}, 16'h0001);
    wr(A_STAT, 8'h40);
    chk("R11 cleared irq", {15'h0, ovfIrq}, 16'h0000);
    rd(A_STAT, b); chk("R11 cleared flag", {15'h0, b[B_OVF]}, 16'h0000);

    // R12: enable gating
    wr(A_STAT, 8'h10);
    ticks(259);
    chk("R12 irq masked", {15'h0, ovfIrq}, 16'h0000);
    rd(A_STAT, b); chk("R12 flag set while masked", {15'h0, b[B_OVF]}, 16'h0001);
    wr(A_STAT, 8'hC0);
    chk("R12 irq enabled", {15'h0, ovfIrq}, 16'h0001);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule